// File: doc/BRIEF.md
# Escaped-Frame Packet Receiver

This block sits behind a byte-oriented serial receiver and turns its byte stream into whole command packets. Each accepted byte, marked by a one-cycle valid strobe, is checked against the frame syntax. The block finds the opening pair, strips the escape bytes that guard payload values equal to the escape code, and stores the length, the command and the data bytes in a register buffer. It keeps a running 8-bit sum and checks the closing pair. When a frame is good it pulses a packet-valid output and presents the command, length and data. When a frame breaks any rule it pulses packet-dropped and goes back to searching.

After a good frame the block holds its outputs and ignores the line until the consumer pulses `consume`. The consumer can therefore read the buffer at its own pace. Bytes that arrive during that time are lost, so the sender must wait for the acknowledgement. Any corrupt frame is dropped, and the block then waits for the next one.

Top module: `frame_rx`

## Requirements
- R1: After reset, `pkt_valid` and `pkt_drop` are low and the block is searching for a frame opening. Any byte presented while `rx_valid` is low is ignored.
- R2: A frame on the wire is 02h, 04h, Len, Cmd, Len data bytes, Sum, 04h, 03h. When it is correct, `pkt_valid` is high for exactly one cycle, in the cycle after the edge that takes the 03h. At that point `pkt_cmd` = Cmd, `pkt_len` = Len, and data byte i sits at `pkt_data[8i+7:8i]`.
- R3: Inside Len, Cmd, data and Sum, a byte of value 04h is sent as 04h 04h. The first 04h is discarded. It is not stored, it does not count toward Len, and it does not enter the sum.
- R4: Len counts only the data bytes and not Cmd. Len = 0 is a valid frame with no data.
- R5: A Len above `MAX_LEN` drops the frame. `pkt_drop` pulses in the cycle after the Len byte is taken.
- R6: The frame is dropped unless (Len + Cmd + all data + Sum) mod 256 = 00h. `pkt_drop` pulses after the Sum byte, and no `pkt_valid` follows for that frame.
- R7: Inside the escaped fields, a 04h followed by any value other than 04h drops the frame.
- R8: An unescaped 02h seen after the opening pair drops the current frame. That 02h is then taken as the start of a new frame.
- R9: After Sum, anything other than 04h then 03h drops the frame, except the 02h case of R8.
- R10: While searching, stray bytes produce no pulse. A 02h followed by a byte other than 04h returns to searching silently, except that a second 02h restarts the opening.
- R11: From the `pkt_valid` pulse until a `consume` pulse, `pkt_cmd`, `pkt_len` and `pkt_data` stay constant and incoming bytes are ignored. After `consume` the block searches again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_valid | input | 1 | Byte strobe from the serial receiver |
| rx_byte | input | 8 | Received byte, sampled when `rx_valid` is high |
| consume | input | 1 | Releases a held packet |
| pkt_valid | output | 1 | One-cycle pulse: a good packet is presented |
| pkt_drop | output | 1 | One-cycle pulse: a frame was rejected |
| pkt_cmd | output | 8 | Command byte of the presented packet |
| pkt_len | output | 8 | Data byte count of the presented packet |
| pkt_data | output | MAX_LEN*8 | Data buffer, byte i at bits 8i+7:8i |

## Verification
A wrong escape state would show up in the very next escaped field. A lost or extra 04h shifts every following byte, so the checksum fails and a drop pulse appears instead of a valid one within one frame. A wrong data counter or length register makes the frame close early or late, which produces the wrong pulse after the Sum position, or wrong bytes in `pkt_data` at the valid pulse. A hold state that leaks lets a second frame change the outputs or pulse valid before `consume`, and the bench tests this directly.

// File: rtl/frx_pkg.sv
package frx_pkg;

    localparam logic [7:0] SYM_START = 8'h02;
    localparam logic [7:0] SYM_STOP  = 8'h03;
    localparam logic [7:0] SYM_ESC   = 8'h04;

    typedef enum logic [3:0] {
        ST_HUNT     = 4'd0,
        ST_OPEN     = 4'd1,
        ST_LEN      = 4'd2,
        ST_CMD      = 4'd3,
        ST_DATA     = 4'd4,
        ST_SUM      = 4'd5,
        ST_TAIL_ESC = 4'd6,
        ST_TAIL_END = 4'd7,
        ST_HOLD     = 4'd8
    } rx_state_e;

endpackage

// File: rtl/frx_unstuff.sv
module frx_unstuff
    import frx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_valid,
    input  logic [7:0] in_byte,
    input  logic       unstuff_en,
    output logic       tok_valid,
    output logic [7:0] tok_byte,
    output logic       tok_escaped
);

    logic esc_d, esc_q;

    always_comb begin
        esc_d       = esc_q;
        tok_valid   = 1'b0;
        tok_byte    = in_byte;
        tok_escaped = 1'b0;
        if (!unstuff_en) begin
            esc_d     = 1'b0;
            tok_valid = in_valid;
        end else if (in_valid) begin
            if (esc_q) begin
                esc_d       = 1'b0;
                tok_valid   = 1'b1;
                tok_escaped = 1'b1;
            end else if (in_byte == SYM_ESC) begin
                esc_d = 1'b1;
            end else begin
                tok_valid = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) esc_q <= 1'b0;
        else        esc_q <= esc_d;
    end

    AST_TOKEN_NEEDS_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        tok_valid |-> in_valid); // R1

    AST_ESC_SWALLOWED: assert property (@(posedge clk) disable iff (!rst_n)
        (unstuff_en && in_valid && !esc_q && in_byte == SYM_ESC) |-> !tok_valid); // R3

endmodule

// File: rtl/frx_parser.sv
module frx_parser
    import frx_pkg::*;
#(
    parameter  int MAX_LEN = 32,
    localparam int LW      = $clog2(MAX_LEN + 1),
    localparam int DW      = MAX_LEN * 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tok_valid,
    input  logic [7:0]    tok_byte,
    input  logic          tok_escaped,
    input  logic          consume,
    output logic          unstuff_en,
    output logic          pkt_valid,
    output logic          pkt_drop,
    output logic [7:0]    pkt_cmd,
    output logic [LW-1:0] pkt_len,
    output logic [DW-1:0] pkt_data
);

    typedef struct packed {
        rx_state_e     state;
        logic [LW-1:0] len;
        logic [LW-1:0] cnt;
        logic [7:0]    cmd;
        logic [7:0]    sum;
        logic [DW-1:0] data;
        logic          valid;
        logic          drop;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        logic [7:0] sum_next;
        int unsigned idx;
        r_d       = r_q;
        r_d.valid = 1'b0;
        r_d.drop  = 1'b0;
        sum_next  = r_q.sum + tok_byte;
        idx       = 32'(r_q.cnt) * 8;
        case (r_q.state)
            ST_HUNT: begin
                if (tok_valid && tok_byte == SYM_START) r_d.state = ST_OPEN;
            end
            ST_OPEN: begin
                if (tok_valid) begin
                    if (tok_byte == SYM_ESC) begin
                        r_d.state = ST_LEN;
                        r_d.cnt   = '0;
                        r_d.sum   = '0;
                    end else if (tok_byte != SYM_START) begin
                        r_d.state = ST_HUNT;
                    end
                end
            end
            ST_HOLD: begin
                if (consume) r_d.state = ST_HUNT;
            end
            default: begin
                if (tok_valid) begin
                    if (!tok_escaped && tok_byte == SYM_START) begin
                        r_d.drop  = 1'b1;
                        r_d.state = ST_OPEN;
                    end else if (tok_escaped && tok_byte != SYM_ESC) begin
                        r_d.drop  = 1'b1;
                        r_d.state = ST_HUNT;
                    end else begin
                        case (r_q.state)
                            ST_LEN: begin
                                if (tok_byte > 8'(MAX_LEN)) begin
                                    r_d.drop  = 1'b1;
                                    r_d.state = ST_HUNT;
                                end else begin
                                    r_d.len   = LW'(tok_byte);
                                    r_d.sum   = tok_byte;
                                    r_d.state = ST_CMD;
                                end
                            end
                            ST_CMD: begin
                                r_d.cmd   = tok_byte;
                                r_d.sum   = sum_next;
                                r_d.state = (r_q.len == '0) ? ST_SUM : ST_DATA;
                            end
                            ST_DATA: begin
                                r_d.data[idx +: 8] = tok_byte;
                                r_d.sum = sum_next;
                                r_d.cnt = r_q.cnt + LW'(1);
                                if (r_q.cnt + LW'(1) == r_q.len) r_d.state = ST_SUM;
                            end
                            ST_SUM: begin
                                if (sum_next == 8'h00) begin
                                    r_d.state = ST_TAIL_ESC;
                                end else begin
                                    r_d.drop  = 1'b1;
                                    r_d.state = ST_HUNT;
                                end
                            end
                            ST_TAIL_ESC: begin
                                if (tok_byte == SYM_ESC) begin
                                    r_d.state = ST_TAIL_END;
                                end else begin
                                    r_d.drop  = 1'b1;
                                    r_d.state = ST_HUNT;
                                end
                            end
                            ST_TAIL_END: begin
                                if (tok_byte == SYM_STOP) begin
                                    r_d.valid = 1'b1;
                                    r_d.state = ST_HOLD;
                                end else begin
                                    r_d.drop  = 1'b1;
                                    r_d.state = ST_HUNT;
                                end
                            end
                            default: r_d.state = ST_HUNT;
                        endcase
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign unstuff_en = (r_q.state == ST_LEN) || (r_q.state == ST_CMD) ||
                        (r_q.state == ST_DATA) || (r_q.state == ST_SUM);
    assign pkt_valid  = r_q.valid;
    assign pkt_drop   = r_q.drop;
    assign pkt_cmd    = r_q.cmd;
    assign pkt_len    = r_q.len;
    assign pkt_data   = r_q.data;

    AST_PULSES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(pkt_valid && pkt_drop)); // R6

    AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_valid |=> !pkt_valid); // R2

    AST_LEN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_CMD || r_q.state == ST_DATA) |-> (r_q.len <= LW'(MAX_LEN))); // R5

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_DATA) |-> (r_q.cnt < r_q.len)); // R4

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_HOLD && $past(r_q.state) == ST_HOLD) |->
        ($stable(r_q.cmd) && $stable(r_q.len) && $stable(r_q.data))); // R11

    AST_HOLD_NO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_HOLD && !consume) |=> (!pkt_valid && !pkt_drop)); // R11

endmodule

// File: rtl/frame_rx.sv
module frame_rx #(
    parameter int MAX_LEN = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rx_valid,
    input  logic [7:0]           rx_byte,
    input  logic                 consume,
    output logic                 pkt_valid,
    output logic                 pkt_drop,
    output logic [7:0]           pkt_cmd,
    output logic [7:0]           pkt_len,
    output logic [MAX_LEN*8-1:0] pkt_data
);

    localparam int LW = $clog2(MAX_LEN + 1);

    logic          unstuff_en;
    logic          tok_valid;
    logic [7:0]    tok_byte;
    logic          tok_escaped;
    logic [LW-1:0] len_w;

    frx_unstuff u_unstuff (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (rx_valid),
        .in_byte     (rx_byte),
        .unstuff_en  (unstuff_en),
        .tok_valid   (tok_valid),
        .tok_byte    (tok_byte),
        .tok_escaped (tok_escaped)
    );

    frx_parser #(.MAX_LEN(MAX_LEN)) u_parser (
        .clk         (clk),
        .rst_n       (rst_n),
        .tok_valid   (tok_valid),
        .tok_byte    (tok_byte),
        .tok_escaped (tok_escaped),
        .consume     (consume),
        .unstuff_en  (unstuff_en),
        .pkt_valid   (pkt_valid),
        .pkt_drop    (pkt_drop),
        .pkt_cmd     (pkt_cmd),
        .pkt_len     (len_w),
        .pkt_data    (pkt_data)
    );

    assign pkt_len = 8'(len_w);

endmodule

// File: tb/frame_rx_test.sv
module frame_rx_test;

    localparam int MAX_LEN = 32;
    localparam int DW      = MAX_LEN * 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rx_valid = 1'b0;
    logic [7:0]    rx_byte = 8'h00;
    logic          consume = 1'b0;
    logic          pkt_valid, pkt_drop;
    logic [7:0]    pkt_cmd, pkt_len;
    logic [DW-1:0] pkt_data;

    int n_checks = 0;
    int n_fails  = 0;
    int n_valid  = 0;
    int n_drop   = 0;

    logic [7:0] g_len;
    logic [7:0] g_cmd;
    logic [7:0] g_dat [MAX_LEN];

    always #4 clk = ~clk;

    frame_rx #(.MAX_LEN(MAX_LEN)) uut (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .consume(consume), .pkt_valid(pkt_valid), .pkt_drop(pkt_drop),
        .pkt_cmd(pkt_cmd), .pkt_len(pkt_len), .pkt_data(pkt_data)
    );

    always @(negedge clk) begin
        if (pkt_valid) n_valid++;
        if (pkt_drop)  n_drop++;
    end

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // one byte, then an idle cycle carrying a start code with rx_valid low (R1)
    task automatic put(input logic [7:0] b);
        @(negedge clk);
        rx_valid = 1'b1;
        rx_byte  = b;
        @(negedge clk);
        rx_valid = 1'b0;
        rx_byte  = 8'h02;
    endtask

    task automatic put_pay(input logic [7:0] b);
        if (b == 8'h04) put(8'h04);
        put(b);
    endtask

    task automatic pulse_consume();
        @(negedge clk);
        consume = 1'b1;
        @(negedge clk);
        consume = 1'b0;
    endtask

    function automatic logic [7:0] frame_sum();
        logic [7:0] s;
        s = g_len + g_cmd;
        for (int i = 0; i < int'(g_len); i++) s = s + g_dat[i];
        return 8'h00 - s;
    endfunction

    task automatic make_frame(input int len, input int seed);
        g_len = 8'(len);
        for (int i = 0; i < MAX_LEN; i++) begin
            g_dat[i] = 8'((i * 37 + len * 11 + seed) & 255);
            if (g_dat[i] == 8'h02) g_dat[i] = 8'h04;
        end
        g_cmd = 8'(seed);
        while (g_cmd == 8'h02 || frame_sum() == 8'h02) g_cmd = g_cmd + 8'h01;
    endtask

    // mode 0 good, 1 bad sum, 2 bad trailer
    task automatic send(input int mode);
        logic [7:0] s;
        s = frame_sum();
        if (mode == 1) s = s + 8'h01;
        if (s == 8'h02) s = s + 8'h01;
        put(8'h02);
        put(8'h04);
        put_pay(g_len);
        put_pay(g_cmd);
        for (int i = 0; i < int'(g_len); i++) put_pay(g_dat[i]);
        put_pay(s);
        put(8'h04);
        put(mode == 2 ? 8'h05 : 8'h03);
        @(negedge clk);
    endtask

    task automatic check_fields(input string tag);
        logic [DW-1:0] exp_d, mask;
        exp_d = '0;
        mask  = '0;
        for (int i = 0; i < int'(g_len); i++) begin
            exp_d[i*8 +: 8] = g_dat[i];
            mask[i*8 +: 8]  = 8'hff;
        end
        check(pkt_len == g_len, {tag, " len"}, 64'(pkt_len), 64'(g_len));
        check(pkt_cmd == g_cmd, {tag, " cmd"}, 64'(pkt_cmd), 64'(g_cmd));
        check((pkt_data & mask) == exp_d, {tag, " data"}, 64'(pkt_data & mask), 64'(exp_d));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        int v0, d0;
        repeat (3) @(negedge clk);
        check(pkt_valid == 1'b0 && pkt_drop == 1'b0, "R1 reset pulses", 64'({pkt_valid, pkt_drop}), 64'(0));
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(n_valid == 0 && n_drop == 0, "R1 idle after reset", 64'(n_valid + n_drop), 64'(0));

        // R2 R3 R4: sweep every length (Len 2 would be a raw start code, see R8)
        for (int len = 0; len <= MAX_LEN; len++) begin
            for (int k = 0; k < 2; k++) begin
                if (len == 2) continue;
                make_frame(len, k == 0 ? 4 : 8'h41 + len);
                v0 = n_valid; d0 = n_drop;
                send(0);
                check(n_valid == v0 + 1 && n_drop == d0, "R2 R3 R4 good frame",
                      64'(n_valid - v0), 64'(1));
                check_fields("R2 R3 R4");
                pulse_consume();
            end
        end

        // R3: Len and Cmd both equal to the escape code
        make_frame(4, 4);
        g_cmd = 8'h04;
        v0 = n_valid;
        if (frame_sum() != 8'h02) begin
            send(0);
            check(n_valid == v0 + 1, "R3 escaped len and cmd", 64'(n_valid - v0), 64'(1));
            check_fields("R3");
            pulse_consume();
        end

        // R5: length over the limit
        d0 = n_drop; v0 = n_valid;
        put(8'h02); put(8'h04); put(8'(MAX_LEN + 1)); @(negedge clk);
        check(n_drop == d0 + 1 && n_valid == v0, "R5 oversize len", 64'(n_drop - d0), 64'(1));

        // R6: bad checksum
        make_frame(6, 9);
        d0 = n_drop; v0 = n_valid;
        send(1);
        check(n_drop == d0 + 1 && n_valid == v0, "R6 bad sum", 64'(n_drop - d0), 64'(1));

        // R9: bad trailer
        make_frame(5, 12);
        d0 = n_drop; v0 = n_valid;
        send(2);
        check(n_drop == d0 + 1 && n_valid == v0, "R9 bad trailer", 64'(n_drop - d0), 64'(1));

        // R7: escape followed by a non-escape value inside the cmd field
        d0 = n_drop; v0 = n_valid;
        put(8'h02); put(8'h04); put(8'h03); put(8'h04); put(8'h05); @(negedge clk);
        check(n_drop == d0 + 1 && n_valid == v0, "R7 bad escape", 64'(n_drop - d0), 64'(1));

        // R8: start code in mid frame restarts on that byte
        make_frame(7, 21);
        d0 = n_drop; v0 = n_valid;
        put(8'h02); put(8'h04); put(8'h09); put(8'h33); put(8'h11);
        send(0);
        check(n_drop == d0 + 1, "R8 abort pulse", 64'(n_drop - d0), 64'(1));
        check(n_valid == v0 + 1, "R8 restarted frame", 64'(n_valid - v0), 64'(1));
        check_fields("R8");
        pulse_consume();

        // R10: noise, a lone start, a doubled start
        d0 = n_drop; v0 = n_valid;
        put(8'h00); put(8'h03); put(8'h04); put(8'hff); put(8'h02); put(8'h55); @(negedge clk);
        check(n_drop == d0 && n_valid == v0, "R10 noise ignored", 64'(n_drop - d0 + n_valid - v0), 64'(0));
        make_frame(3, 50);
        put(8'h02);
        send(0);
        check(n_valid == v0 + 1 && n_drop == d0, "R10 doubled start", 64'(n_valid - v0), 64'(1));
        check_fields("R10");

        // R11: held packet survives a second frame; consume releases it
        v0 = n_valid; d0 = n_drop;
        make_frame(9, 77);
        send(0);
        make_frame(3, 50);
        check(n_valid == v0 && n_drop == d0, "R11 no pulse while held", 64'(n_valid - v0), 64'(0));
        check_fields("R11 held");
        pulse_consume();
        make_frame(9, 77);
        send(0);
        check(n_valid == v0 + 1, "R11 accepted after consume", 64'(n_valid - v0), 64'(1));
        check_fields("R11 new");
        pulse_consume();

        repeat (4) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule